// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

This block divides one unsigned integer by another without long division. It counts how many times the divisor can be taken away from a running remainder, one subtraction per clock. A request is a one-cycle `start` strobe with the dividend and divisor on the input buses. The block then works alone until it raises `done` for one cycle. At that point the quotient, the remainder and a divide-by-zero flag are valid, and they stay held until the next accepted request.

The remainder register is one bit wider than the operands. The last subtraction may go past zero, and the extra bit holds the borrow of that subtraction. The sign of the remainder is never used. When the borrow appears, one correction cycle adds the divisor back and takes one off the count. Two cases finish straight away without any subtraction: a zero divisor, and a dividend smaller than the divisor. Latency therefore grows with the quotient value. This suits places where operands are small or where throughput does not matter.

Top module: `rsub_divider`

## Requirements
- R1: After reset `busy`, `done` and `div_err` are 0, and `quotient` and `remainder` are 0.
- R2: With a zero divisor, `done` rises 2 cycles after the start edge, with `div_err`=1, `quotient` all ones and `remainder`=0. No subtraction is performed.
- R3: With a dividend below a nonzero divisor, `done` rises 2 cycles after the start edge, with `quotient`=0, `remainder` equal to the dividend and `div_err`=0.
- R4: With a nonzero divisor, the result on `done` is `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor, so `remainder` is always below the divisor.
- R5: When the divisor divides a dividend at least as large as itself exactly, the last subtraction leaves exactly zero. The block finishes with no correction, and `done` rises quotient+2 cycles after the start edge.
- R6: When the division leaves a nonzero remainder and dividend >= divisor, one extra subtraction produces a borrow in the widened remainder. The block then spends one cycle adding the divisor back and decrementing the count, and `done` rises quotient+4 cycles after the start edge.
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after the accepted start through the `done` cycle, and low again on the following cycle.
- R8: While the block is idle and `start` is low, `quotient`, `remainder` and `div_err` keep their values.
- R9: A `start` pulse while `busy` is high is ignored. The running division finishes with its original operands and timing.
- R10: An accepted request clears `div_err` that an earlier divide-by-zero left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when `busy` is low |
| dividend | input | W | Unsigned dividend, sampled with `start` |
| divisor | input | W | Unsigned divisor, sampled with `start` |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| div_err | output | 1 | The last request had a zero divisor |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |

## Verification
The add-back path is the hardest case to reach deliberately from the ports. It needs an overshooting subtraction, so the dividend must not be a multiple of the divisor and must be at least as large as it. The correction must also land in the cycle right after the overshoot. A 4-bit instance is swept over every dividend and divisor pair, so every quotient and remainder combination takes either the exact or the overshoot ending. The done-pulse latency is measured against quotient+2 or quotient+4, which tells the two endings apart. A separate run fires `start` in the middle of a long 15/1 division to show that the busy guard holds.

// File: rtl/rsub_div_pkg.sv
package rsub_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_SUB   = 3'd2,
    ST_FIX   = 3'd3,
    ST_FIN   = 3'd4
  } div_state_e;

endpackage

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
  import rsub_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dsr_zero,
  input  logic rem_lt_dsr,
  input  logic diff_borrow,
  input  logic diff_zero,
  output logic do_load,
  output logic do_err,
  output logic do_sub,
  output logic do_fix,
  output logic busy,
  output logic done
);

  div_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    do_load = 1'b0;
    do_err  = 1'b0;
    do_sub  = 1'b0;
    do_fix  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          do_load = 1'b1;
          st_d    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (dsr_zero) begin
          do_err = 1'b1;
          st_d   = ST_FIN;
        end else if (rem_lt_dsr) begin
          st_d = ST_FIN;
        end else begin
          st_d = ST_SUB;
        end
      end
      ST_SUB: begin
        do_sub = 1'b1;
        if (diff_borrow)    st_d = ST_FIX;
        else if (diff_zero) st_d = ST_FIN;
        else                st_d = ST_SUB;
      end
      ST_FIX: begin
        do_fix = 1'b1;
        st_d   = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_FIN);

endmodule

// File: rtl/rsub_datapath.sv
module rsub_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         do_load,
  input  logic         do_err,
  input  logic         do_sub,
  input  logic         do_fix,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         dsr_zero,
  output logic         rem_lt_dsr,
  output logic         diff_borrow,
  output logic         diff_zero,
  output logic         ev_overshoot,
  output logic [W-1:0] dsr_out,
  output logic [W-1:0] quot_out,
  output logic [W-1:0] rem_out,
  output logic         err_out
);

  localparam int RW = W + 1;

  // One trial subtraction in a widened word; the top bit is the borrow.
  function automatic logic [RW-1:0] sub_step(input logic [W-1:0] r,
                                             input logic [W-1:0] d);
    return {1'b0, r} - {1'b0, d};
  endfunction

  // Undo an overshoot: wraps modulo 2**RW back to the non-negative value.
  function automatic logic [RW-1:0] add_back(input logic [RW-1:0] r,
                                             input logic [W-1:0]  d);
    return r + {1'b0, d};
  endfunction

  logic [RW-1:0] rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic          err_q;
  logic [RW-1:0] diff;

  assign diff         = sub_step(rem_q[W-1:0], dsr_q);
  assign diff_borrow  = diff[W];
  assign diff_zero    = (diff == '0);
  assign dsr_zero     = (dsr_q == '0);
  assign rem_lt_dsr   = (rem_q[W-1:0] < dsr_q);
  assign ev_overshoot = do_sub & diff_borrow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      err_q <= 1'b0;
    end else if (do_load) begin
      rem_q <= {1'b0, dividend};
      quo_q <= '0;
      dsr_q <= divisor;
      err_q <= 1'b0;
    end else if (do_err) begin
      rem_q <= '0;
      quo_q <= '1;
      err_q <= 1'b1;
    end else if (do_sub) begin
      rem_q <= diff;
      quo_q <= quo_q + 1'b1;
    end else if (do_fix) begin
      rem_q <= add_back(rem_q, dsr_q);
      quo_q <= quo_q - 1'b1;
    end
  end

  assign dsr_out  = dsr_q;
  assign quot_out = quo_q;
  assign rem_out  = rem_q[W-1:0];
  assign err_out  = err_q;

endmodule

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  logic do_load, do_err, do_sub, do_fix;
  logic dsr_zero, rem_lt_dsr, diff_borrow, diff_zero;
  logic ev_overshoot;
  logic ev_fix;
  logic [W-1:0] dsr_q;

  rsub_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dsr_zero   (dsr_zero),
    .rem_lt_dsr (rem_lt_dsr),
    .diff_borrow(diff_borrow),
    .diff_zero  (diff_zero),
    .do_load    (do_load),
    .do_err     (do_err),
    .do_sub     (do_sub),
    .do_fix     (do_fix),
    .busy       (busy),
    .done       (done)
  );

  rsub_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_load     (do_load),
    .do_err      (do_err),
    .do_sub      (do_sub),
    .do_fix      (do_fix),
    .dividend    (dividend),
    .divisor     (divisor),
    .dsr_zero    (dsr_zero),
    .rem_lt_dsr  (rem_lt_dsr),
    .diff_borrow (diff_borrow),
    .diff_zero   (diff_zero),
    .ev_overshoot(ev_overshoot),
    .dsr_out     (dsr_q),
    .quot_out    (quotient),
    .rem_out     (remainder),
    .err_out     (div_err)
  );

  assign ev_fix = do_fix;

endmodule

// File: rtl/rsub_div_chk.sv
module rsub_div_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] dsr_q,
  input logic         ev_overshoot,
  input logic         ev_fix
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_err_values_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> (quotient == {W{1'b1}} && remainder == '0));

  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err) |-> (remainder < dsr_q));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_err)));

  p_fix_after_overshoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overshoot |=> ev_fix);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dsr_q));

endmodule

bind rsub_divider rsub_div_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .div_err     (div_err),
  .quotient    (quotient),
  .remainder   (remainder),
  .dsr_q       (dsr_q),
  .ev_overshoot(ev_overshoot),
  .ev_fix      (ev_fix)
);

// File: tb/test_rsub_divider.sv
module test_rsub_divider;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_err;
  logic [W-1:0] quotient, remainder;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rsub_divider #(.W(W)) i_rsub_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .div_err  (div_err),
    .quotient (quotient),
    .remainder(remainder)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Wait at negedges for done; returns cycles counted from the start edge.
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_div(input int a, input int b, input bit after_err);
    int lat, eq, er, elat;
    @(negedge clk);
    dividend = W'(a);
    divisor  = W'(b);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "done right after start edge", int'(done), 0);
    wait_done(lat);
    if (b == 0) begin
      eq = N - 1; er = 0; elat = 2;
      check("R2", "error flag", int'(div_err), 1);
      check("R2", "quotient on zero divisor", int'(quotient), eq);
      check("R2", "remainder on zero divisor", int'(remainder), er);
      check("R2", "latency", lat, elat);
    end else begin
      eq = a / b; er = a % b;
      if (a < b)       elat = 2;
      else if (er == 0) elat = eq + 2;
      else             elat = eq + 4;
      check(after_err ? "R10" : "R4", "error flag", int'(div_err), 0);
      check(a < b ? "R3" : "R4", "quotient", int'(quotient), eq);
      check(a < b ? "R3" : "R4", "remainder", int'(remainder), er);
      check(a < b ? "R3" : (er == 0 ? "R5" : "R6"), "latency", lat, elat);
    end
    @(negedge clk);
    check("R7", "done dropped after one cycle", int'(done), 0);
    check("R7", "busy dropped after done", int'(busy), 0);
    @(negedge clk);
    check("R8", "quotient held while idle", int'(quotient), eq);
    check("R8", "remainder held while idle", int'(remainder), er);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "error after reset", int'(div_err), 0);
    check("R1", "quotient after reset", int'(quotient), 0);
    check("R1", "remainder after reset", int'(remainder), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep; each zero-divisor case is followed by a clearing run.
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        run_div(a, b, b == 1);
      end
    end

    // R9: a start strobe in the middle of a long 15/1 run has no effect.
    @(negedge clk);
    dividend = W'(15); divisor = W'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = W'(7); divisor = W'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "busy kept during run", int'(busy), 1);
    wait_done(lat);
    check("R9", "latency unaffected", lat + 4, 17);
    check("R9", "quotient unaffected", int'(quotient), 15);
    check("R9", "remainder unaffected", int'(remainder), 0);
    @(negedge clk);
    check("R9", "no second result", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R9", "no extra done", int'(done), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule